// File: doc/BRIEF.md
# Fetch Packet Instruction Unpacker

The unpacker accepts one 256-bit fetch packet of eight 32-bit words and hands its instructions out one per transfer, in logical order. Each output carries the opcode, a flag that marks a 16-bit instruction, the halfword offset of the instruction inside the packet, a parallel-with-next flag and a flag that marks the final instruction of the packet.

A packet may end in a header word. When it does, each of the first seven words can be declared compact, meaning it carries two 16-bit instructions. The parallel flags of those halfword instructions come from a bitmap in the header, and a handful of control fields in the header are presented as sideband outputs. Without a header, all eight words are plain 32-bit instructions. Either byte order is supported, selected by a per-packet input.

Input and output both use valid/ready handshakes. A new packet is taken only once the last instruction of the current one has been handed off. The final instruction's parallel flag is visible with the last-marker, so a downstream grouper can continue an execute packet across packet boundaries.

Top module: `pkt_unpacker`

## Requirements
- R1: Byte i of the packet is `inPacket[8*i+7:8*i]`. Word w is made of bytes 4w..4w+3. The packet has a header only when bits 31:28 of word 7 equal 4'hE (`hdrPresent`=1). Otherwise all eight words are emitted as 32-bit instructions.
- R2: With a header, header bit 21+w (w = 0..6) set marks word w as compact. A compact word yields two 16-bit instructions (`outIsHalf`=1, opcode in bits 15:0 of `outOpcode`, upper bits zero). Other words yield one 32-bit instruction.
- R3: While a packet is held, the sideband outputs show the header fields as follows: `hdrProtect` = bit 20, `hdrRegSet` = bit 19, `hdrDataSize` = bits 18:16, `hdrBranch` = bit 15, `hdrSaturate` = bit 14.
- R4: A 16-bit instruction at halfword offset s (s = 2w+h, h = 0 for the first half and 1 for the second) takes its parallel flag from header bit s.
- R5: The parallel flag of a 32-bit instruction is bit 0 of its opcode.
- R6: The header word is never emitted: with a header, only words 0..6 produce instructions, so `outHalfIdx` stays below 14.
- R7: With `inBigEndian`=0, byte 4w is the least significant byte of word w. With `inBigEndian`=1, byte 4w is the most significant. In both orders, bits 15:0 of the word are the logically first halfword instruction.
- R8: Instructions leave in ascending halfword offset. A 32-bit instruction in word w reports offset 2w.
- R9: `inReady` is 1 only when no packet is held. After a packet is accepted, `outValid` rises on the next cycle. While `outValid`=1 and `outReady`=0, all output fields hold. Input activity while a packet is held has no effect.
- R10: `outLast` is 1 only on the final instruction, and that instruction shows its own parallel flag. After it is taken, `outValid` drops and `inReady` returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Packet offered |
| inReady | output | 1 | Packet can be accepted |
| inPacket | input | 256 | Packet bytes, byte i at bits 8i+7:8i |
| inBigEndian | input | 1 | Byte order of the offered packet |
| outValid | output | 1 | Instruction offered |
| outReady | input | 1 | Instruction taken |
| outOpcode | output | 32 | Instruction bits, zero-extended for 16-bit |
| outIsHalf | output | 1 | Instruction is 16 bits |
| outHalfIdx | output | 4 | Halfword offset in the packet |
| outParallel | output | 1 | Executes in parallel with the next instruction |
| outLast | output | 1 | Final instruction of the packet |
| hdrPresent | output | 1 | Held packet has a header |
| hdrProtect | output | 1 | Header protected-load flag |
| hdrRegSet | output | 1 | Header register-set flag |
| hdrDataSize | output | 3 | Header data-size field |
| hdrBranch | output | 1 | Header branch flag |
| hdrSaturate | output | 1 | Header saturation flag |

## Verification
A packet that is accepted at one rising edge shows its first instruction on `outValid` from that edge onward. Each later instruction appears one edge after the previous one is taken. The bench drives inputs and samples outputs on falling edges, so every check falls half a cycle after the edge that produced the value. For a stall, the bench holds `outReady` low for one extra edge and checks that the same instruction is still there. After the final hand-off, it checks on the next falling edge that `outValid` is 0 and `inReady` is 1. Sideband fields are checked while the first instruction of a header packet is on the output.

// File: rtl/pkt_unpack_pkg.sv
package pkt_unpack_pkg;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = WORD_W / 2;
  localparam int WORDS     = 8;
  localparam int PKT_W     = WORD_W * WORDS;
  localparam int WIDX_W    = $clog2(WORDS);
  localparam int HIDX_W    = WIDX_W + 1;
  localparam int HDR_WORD  = WORDS - 1;
  // header field positions
  localparam int HB_COMPACT = 21;
  localparam int HB_PROT    = 20;
  localparam int HB_RS      = 19;
  localparam int HB_DSZ     = 16;
  localparam int HB_BR      = 15;
  localparam int HB_SAT     = 14;

  typedef struct packed {
    logic              load;
    logic [WIDX_W-1:0] wordIdx;
    logic              halfSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/pkt_unpack_dp.sv
module pkt_unpack_dp
  import pkt_unpack_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       stb,
  input  logic [PKT_W-1:0]   inPacket,
  input  logic               inBigEndian,
  output logic [WORDS-1:0]   compactEff,
  output logic               hasHdr,
  output logic [WORD_W-1:0]  opcode,
  output logic               isHalf,
  output logic [HIDX_W-1:0]  halfIdx,
  output logic               parallel,
  output logic               hProt,
  output logic               hRegSet,
  output logic [2:0]         hDataSize,
  output logic               hBranch,
  output logic               hSat
);
  logic [PKT_W-1:0]  pktReg;
  logic              bigReg;
  logic [WORD_W-1:0] logWord [WORDS];
  logic [WORD_W-1:0] hdrWord;
  logic [WORD_W-1:0] curWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktReg <= '0;
      bigReg <= 1'b0;
    end else if (stb.load) begin
      pktReg <= inPacket;
      bigReg <= inBigEndian;
    end
  end

  // byte order: assemble each logical word
  for (genvar w = 0; w < WORDS; w++) begin : gWord
    for (genvar j = 0; j < 4; j++) begin : gByte
      assign logWord[w][8*j +: 8] = bigReg ? pktReg[8*(4*w+3-j) +: 8]
                                           : pktReg[8*(4*w+j) +: 8];
    end
  end

  assign hdrWord = logWord[HDR_WORD];
  assign hasHdr  = (hdrWord[WORD_W-1 -: 4] == 4'hE);

  for (genvar w = 0; w < WORDS; w++) begin : gCompact
    if (w < HDR_WORD) begin : gFlag
      assign compactEff[w] = hasHdr && hdrWord[HB_COMPACT + w];
    end else begin : gNone
      assign compactEff[w] = 1'b0;
    end
  end

  always_comb begin
    curWord = logWord[stb.wordIdx];
    isHalf  = compactEff[stb.wordIdx];
    halfIdx = {stb.wordIdx, isHalf & stb.halfSel};
    if (isHalf) begin
      opcode   = {{HALF_W{1'b0}}, (stb.halfSel ? curWord[WORD_W-1:HALF_W]
                                               : curWord[HALF_W-1:0])};
      parallel = hdrWord[halfIdx];
    end else begin
      opcode   = curWord;
      parallel = curWord[0];
    end
  end

  assign hProt     = hasHdr & hdrWord[HB_PROT];
  assign hRegSet   = hasHdr & hdrWord[HB_RS];
  assign hDataSize = hasHdr ? hdrWord[HB_DSZ +: 3] : 3'd0;
  assign hBranch   = hasHdr & hdrWord[HB_BR];
  assign hSat      = hasHdr & hdrWord[HB_SAT];
endmodule

// File: rtl/pkt_unpack_ctrl.sv
module pkt_unpack_ctrl
  import pkt_unpack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast,
  input  logic [WORDS-1:0] compactEff,
  input  logic             hasHdr,
  output ctrlStrobes_t     stb
);
  logic              busy;
  logic [WIDX_W-1:0] wordIdx;
  logic              halfSel;
  logic [WIDX_W-1:0] lastWord;
  logic              curCompact;

  assign lastWord   = hasHdr ? WIDX_W'(HDR_WORD - 1) : WIDX_W'(WORDS - 1);
  assign curCompact = compactEff[wordIdx];
  assign inReady    = !busy;
  assign outValid   = busy;
  assign outLast    = busy && (wordIdx == lastWord) && (!curCompact || halfSel);

  assign stb.load    = inValid && !busy;
  assign stb.wordIdx = wordIdx;
  assign stb.halfSel = halfSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      wordIdx <= '0;
      halfSel <= 1'b0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      wordIdx <= '0;
      halfSel <= 1'b0;
    end else if (busy && outReady) begin
      if (outLast) begin
        busy <= 1'b0;
      end else if (curCompact && !halfSel) begin
        halfSel <= 1'b1;
      end else begin
        halfSel <= 1'b0;
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_unpacker.sv
module pkt_unpacker
  import pkt_unpack_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [PKT_W-1:0]   inPacket,
  input  logic               inBigEndian,
  output logic               outValid,
  input  logic               outReady,
  output logic [WORD_W-1:0]  outOpcode,
  output logic               outIsHalf,
  output logic [HIDX_W-1:0]  outHalfIdx,
  output logic               outParallel,
  output logic               outLast,
  output logic               hdrPresent,
  output logic               hdrProtect,
  output logic               hdrRegSet,
  output logic [2:0]         hdrDataSize,
  output logic               hdrBranch,
  output logic               hdrSaturate
);
  ctrlStrobes_t     stb;
  logic [WORDS-1:0] compactEff;

  pkt_unpack_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .compactEff(compactEff), .hasHdr(hdrPresent), .stb(stb)
  );

  pkt_unpack_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .inPacket(inPacket),
    .inBigEndian(inBigEndian), .compactEff(compactEff), .hasHdr(hdrPresent),
    .opcode(outOpcode), .isHalf(outIsHalf), .halfIdx(outHalfIdx),
    .parallel(outParallel), .hProt(hdrProtect), .hRegSet(hdrRegSet),
    .hDataSize(hdrDataSize), .hBranch(hdrBranch), .hSat(hdrSaturate)
  );
endmodule

// File: rtl/pkt_unpacker_chk.sv
module pkt_unpacker_chk
  import pkt_unpack_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outOpcode,
  input logic              outIsHalf,
  input logic [HIDX_W-1:0] outHalfIdx,
  input logic              outParallel,
  input logic              outLast,
  input logic              hdrPresent
);
  AST_NOHDR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !hdrPresent |-> !outIsHalf);                             // R1
  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIsHalf |-> outOpcode[WORD_W-1:HALF_W] == '0);        // R2
  AST_FULL_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outIsHalf |-> !outHalfIdx[0]);                         // R8
  AST_HDR_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && hdrPresent |-> outHalfIdx < HIDX_W'(2*HDR_WORD));       // R6
  AST_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !outLast |=> outValid && (outHalfIdx > $past(outHalfIdx))); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outOpcode) && $stable(outHalfIdx)
      && $stable(outParallel) && $stable(outLast));                     // R9
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);                                             // R9
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid && inReady);          // R10
endmodule

bind pkt_unpacker pkt_unpacker_chk uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outOpcode(outOpcode), .outIsHalf(outIsHalf),
  .outHalfIdx(outHalfIdx), .outParallel(outParallel), .outLast(outLast),
  .hdrPresent(hdrPresent)
);

// File: tb/tb_pkt_unpacker.sv
`timescale 1ns/1ps
module tb_pkt_unpacker;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [255:0] inPacket = '0;
  logic         inBigEndian = 1'b0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [31:0]  outOpcode;
  logic         outIsHalf;
  logic [3:0]   outHalfIdx;
  logic         outParallel;
  logic         outLast;
  logic         hdrPresent, hdrProtect, hdrRegSet, hdrBranch, hdrSaturate;
  logic [2:0]   hdrDataSize;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  pkt_unpacker dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPacket(inPacket), .inBigEndian(inBigEndian), .outValid(outValid),
    .outReady(outReady), .outOpcode(outOpcode), .outIsHalf(outIsHalf),
    .outHalfIdx(outHalfIdx), .outParallel(outParallel), .outLast(outLast),
    .hdrPresent(hdrPresent), .hdrProtect(hdrProtect), .hdrRegSet(hdrRegSet),
    .hdrDataSize(hdrDataSize), .hdrBranch(hdrBranch), .hdrSaturate(hdrSaturate)
  );

  // stimulus table: logical words (word w at bits 32w+31:32w), byte order, expected count
  localparam int NVEC = 6;
  localparam logic [255:0] VEC_WORDS [NVEC] = '{
    256'h12345671_80000001_0F0F0F0E_ABCDEF01_00000000_FFFFFFFF_DEADBEEF_00000003,
    256'h12345671_80000001_0F0F0F0E_ABCDEF01_00000000_FFFFFFFF_DEADBEEF_00000003,
    256'hE0154000_80000001_0F0F0F0E_ABCDEF01_00000000_FFFFFFFF_DEADBEEF_00000003,
    256'hEFEAAAAA_70017002_60016002_50015002_40014002_30013002_20012002_10011002,
    256'hE4A01335_0000A001_9BCD1234_00000005_8002C003_00000006_A5A55A5A_13572468,
    256'hF0000001_11111111_22222222_33333333_44444444_55555555_66666666_77777770
  };
  localparam bit VEC_BIG [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int VEC_CNT [NVEC] = '{8, 8, 7, 14, 10, 8};

  logic [31:0] expOp  [16];
  logic        expHalf[16];
  logic [3:0]  expIdx [16];
  logic        expPar [16];
  int          expN;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] toBytes(input logic [255:0] lw, input bit big);
    logic [255:0] p;
    for (int w = 0; w < 8; w++)
      for (int j = 0; j < 4; j++)
        p[8*(4*w+j) +: 8] = big ? lw[32*w + 8*(3-j) +: 8] : lw[32*w + 8*j +: 8];
    return p;
  endfunction

  task automatic buildExp(input logic [255:0] lw);
    bit hdr;
    hdr  = (lw[255:252] == 4'hE);
    expN = 0;
    for (int w = 0; w < (hdr ? 7 : 8); w++) begin
      logic [31:0] word;
      word = lw[32*w +: 32];
      if (hdr && lw[224 + 21 + w]) begin
        for (int h = 0; h < 2; h++) begin
          expOp[expN]   = {16'h0, word[16*h +: 16]};
          expHalf[expN] = 1'b1;
          expIdx[expN]  = 4'(2*w + h);
          expPar[expN]  = lw[224 + 2*w + h];
          expN++;
        end
      end else begin
        expOp[expN]   = word;
        expHalf[expN] = 1'b0;
        expIdx[expN]  = 4'(2*w);
        expPar[expN]  = word[0];
        expN++;
      end
    end
  endtask

  task automatic checkInstr(input int k);
    chk(outValid == 1'b1, "R9 outValid", 32'(outValid), 32'd1);
    chk(inReady == 1'b0, "R9 inReady busy", 32'(inReady), 32'd0);
    chk(outOpcode == expOp[k], "R7/R2 opcode", outOpcode, expOp[k]);
    chk(outIsHalf == expHalf[k], "R2 width", 32'(outIsHalf), 32'(expHalf[k]));
    chk(outHalfIdx == expIdx[k], "R8 halfIdx", 32'(outHalfIdx), 32'(expIdx[k]));
    chk(outParallel == expPar[k], expHalf[k] ? "R4 parallel" : "R5 parallel",
        32'(outParallel), 32'(expPar[k]));
    chk(outLast == (k == expN-1), "R10 last", 32'(outLast), 32'(k == expN-1));
  endtask

  task automatic runVec(input int v);
    logic [255:0] lw;
    lw = VEC_WORDS[v];
    buildExp(lw);
    chk(expN == VEC_CNT[v], "R6 table count", 32'(expN), 32'(VEC_CNT[v]));
    @(negedge clk);
    inPacket    = toBytes(lw, VEC_BIG[v]);
    inBigEndian = VEC_BIG[v];
    inValid     = 1'b1;
    outReady    = 1'b1;
    @(negedge clk);
    if (v == 2) begin
      // R9: input while busy must be ignored
      inPacket    = {8{32'hE7FFFFFF}};
      inBigEndian = 1'b1;
    end else begin
      inValid = 1'b0;
    end
    chk(hdrPresent == (lw[255:252] == 4'hE), "R1 hdrPresent",
        32'(hdrPresent), 32'(lw[255:252] == 4'hE));
    if (lw[255:252] == 4'hE) begin
      chk({hdrProtect, hdrRegSet, hdrDataSize, hdrBranch, hdrSaturate} == lw[224+14 +: 7],
          "R3 sideband", 32'({hdrProtect, hdrRegSet, hdrDataSize, hdrBranch, hdrSaturate}),
          32'(lw[224+14 +: 7]));
    end
    for (int k = 0; k < expN; k++) begin
      checkInstr(k);
      if (k % 3 == 1) begin
        outReady = 1'b0;
        @(negedge clk);
        checkInstr(k);   // R9 stall holds
        outReady = 1'b1;
      end
      @(negedge clk);
      if (k == expN-1) inValid = 1'b0;
    end
    chk(outValid == 1'b0, "R10 outValid drop", 32'(outValid), 32'd0);
    chk(inReady == 1'b1, "R10 inReady back", 32'(inReady), 32'd1);
  endtask

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R9 reset outValid", 32'(outValid), 32'd0);
    chk(inReady == 1'b1, "R9 reset inReady", 32'(inReady), 32'd1);
    chk(hdrPresent == 1'b0, "R1 reset hdrPresent", 32'(hdrPresent), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) runVec(v);
    // directed: acceptance latency, output appears one edge after acceptance
    @(negedge clk);
    inPacket    = toBytes(VEC_WORDS[3], 1'b0);
    inBigEndian = 1'b0;
    inValid     = 1'b1;
    outReady    = 1'b0;
    chk(outValid == 1'b0, "R9 before accept", 32'(outValid), 32'd0);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, "R9 after accept", 32'(outValid), 32'd1);
    chk(outParallel == 1'b0 && outHalfIdx == 4'd0, "R4 first slot",
        32'({outParallel, outHalfIdx}), 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule